// File: doc/BRIEF.md
# Edge Capture Unit with Optional Glitch Filter

This block timestamps transitions on an asynchronous input pin. It watches the pin through a synchronizer. When it sees a transition of the chosen polarity, it copies the value of a free-running 16-bit timer into a holding register and sets a sticky event flag. Software logic, or a neighbouring block, reads the held value and acknowledges the event with a one-cycle clear strobe.

Two configuration inputs shape the trigger. The first, `edge_rise`, selects which direction of transition counts. The second, `filt_on`, inserts a digital glitch filter. The filter runs at the full system clock rate. It accepts a new pin level only when the most recent four synchronized samples all agree on that level. The block keeps an "accepted level" that changes only on a qualified transition. Because of this, a long steady level never re-triggers, and changing the polarity selection cannot manufacture an event.

Top module: `icap_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cap_val` reads 0 and `cap_flag` reads 0.
- R2: With `filt_on`=0 and `edge_rise`=0, a high-to-low pin change captures. The stored value is the `tmr_val` present at the third rising clock edge that follows the pin change, with two synchronizer stages and one decision stage. A single-cycle pulse is enough.
- R3: `edge_rise`=1 selects low-to-high transitions and `edge_rise`=0 selects high-to-low ones. A transition of the unselected direction never captures.
- R4: With `filt_on`=1, a new level captures only after four consecutive synchronized samples show it. The captured `tmr_val` is the one present at the sixth rising edge after the pin change, which is three edges later than in R2. A level held for exactly four cycles qualifies.
- R5: With `filt_on`=1, a pin excursion of three cycles or fewer causes no capture. `cap_flag` stays 0 and `cap_val` is unchanged.
- R6: Each accepted transition produces exactly one capture. A level that stays steady afterwards causes no further capture, and `cap_val` changes only on a capture.
- R7: A capture stores all 16 bits of `tmr_val` and sets `cap_flag`. The flag then stays set until `flag_clr` is sampled high, which clears it on the next edge.
- R8: When a capture and `flag_clr` occur on the same clock edge, the capture wins and `cap_flag` is 1 afterwards.
- R9: Toggling `edge_rise` while the pin is steady produces no capture.
- R10: For the first seven clock edges after reset the block only learns the pin level and never captures. A pin that is already high at reset therefore produces no event, even with `edge_rise`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous pin to timestamp |
| tmr_val | input | 16 | Live value of the free-running timer |
| edge_rise | input | 1 | 1 = capture on rising transitions, 0 = on falling |
| filt_on | input | 1 | 1 = require four agreeing samples |
| flag_clr | input | 1 | One-cycle acknowledge that clears the flag |
| cap_val | output | 16 | Timer value held at the last capture |
| cap_flag | output | 1 | Sticky capture-event flag |

## Verification
The checker watches, on every cycle, the internal trigger against the outputs. It checks that a trigger loads exactly the previous cycle's timer value, that the held value never moves without a trigger, and that the flag obeys its set, hold and clear precedence. It also checks that no trigger occurs during warm-up and that each trigger coincides with a change of the accepted level. Only the bench's scenarios can show which transitions deserve a trigger and the exact edge on which it fires. These include the polarity choice, filtered versus unfiltered latency, rejection of short glitches, the exactly-four-cycle boundary, and the absence of events on polarity toggles or at reset.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int CNT_W    = 16;
    localparam int SYNC_LEN = 2;
    localparam int FILT_LEN = 4;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } pol_e;

    // transition of the accepted level seen this cycle
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic edge_hit(edge_t e, pol_e p);
        return (p == POL_RISE) ? e.rise : e.fall;
    endfunction

    function automatic logic all_same(logic [FILT_LEN-1:0] w, logic lvl);
        return lvl ? (&w) : ~(|w);
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/icap_qualify.sv
module icap_qualify
    import icap_pkg::*;
#(
    parameter int FILT = 4,
    parameter int WARM = 7
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  smp,
    input  logic  filt_en,
    output edge_t ev,
    output logic  lvl_o,
    output logic  armed_o
);
    localparam int WW = $clog2(WARM + 1);

    logic [FILT-2:0] hist;
    logic [FILT-1:0] window;
    logic            lvl_q;
    logic            lvl_d;
    logic [WW-1:0]   warm_q;
    logic            armed;

    // history of past synchronized samples
    generate
        if (FILT == 2) begin : g_hist_one
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= smp;
            end
        end else begin : g_hist_many
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= {hist[FILT-3:0], smp};
            end
        end
    endgenerate

    assign window = {hist, smp};
    assign armed  = (warm_q == WW'(WARM));

    always_comb begin
        lvl_d = lvl_q;
        if (!filt_en)                     lvl_d = smp;
        else if (all_same(window, 1'b1))  lvl_d = 1'b1;
        else if (all_same(window, 1'b0))  lvl_d = 1'b0;
    end

    always_comb begin
        ev.rise = armed &  lvl_d & ~lvl_q;
        ev.fall = armed & ~lvl_d &  lvl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            warm_q <= '0;
        end else begin
            lvl_q <= lvl_d;
            if (!armed) warm_q <= warm_q + 1'b1;
        end
    end

    assign lvl_o   = lvl_q;
    assign armed_o = armed;
endmodule

// File: rtl/icap_store.sv
module icap_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig,
    input  logic         clr,
    input  logic [W-1:0] tmr,
    output logic [W-1:0] held,
    output logic         flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            flag <= 1'b0;
        end else begin
            if (trig) held <= tmr;
            if (trig)     flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/icap_top.sv
module icap_top
    import icap_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int NSYNC = SYNC_LEN,
    parameter int NFILT = FILT_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_pin,
    input  logic [W-1:0] tmr_val,
    input  logic         edge_rise,
    input  logic         filt_on,
    input  logic         flag_clr,
    output logic [W-1:0] cap_val,
    output logic         cap_flag
);
    localparam int WARM = NSYNC + NFILT + 1;

    logic  pin_s;
    edge_t ev;
    logic  acc_lvl;
    logic  armed;
    logic  trig;

    icap_sync #(.STAGES(NSYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_pin),
        .dout (pin_s)
    );

    icap_qualify #(.FILT(NFILT), .WARM(WARM)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .smp     (pin_s),
        .filt_en (filt_on),
        .ev      (ev),
        .lvl_o   (acc_lvl),
        .armed_o (armed)
    );

    assign trig = edge_hit(ev, pol_e'(edge_rise));

    icap_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .clr  (flag_clr),
        .tmr  (tmr_val),
        .held (cap_val),
        .flag (cap_flag)
    );
endmodule

// File: rtl/icap_checker.sv
module icap_checker
    import icap_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] tmr_val,
    input logic         flag_clr,
    input logic [W-1:0] cap_val,
    input logic         cap_flag,
    input logic         trig,
    input logic         armed,
    input logic         acc_lvl,
    input edge_t        ev
);
    p_copy_r7: assert property (@(posedge clk) disable iff (rst)
        trig |=> cap_val == $past(tmr_val));

    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        trig |=> cap_flag);

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        cap_flag && !flag_clr |=> cap_flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        flag_clr && !trig |=> !cap_flag);

    p_cap_beats_clr_r8: assert property (@(posedge clk) disable iff (rst)
        trig && flag_clr |=> cap_flag);

    p_val_steady_r6: assert property (@(posedge clk) disable iff (rst)
        !trig |=> $stable(cap_val));

    p_level_moves_r9: assert property (@(posedge clk) disable iff (rst)
        trig |=> acc_lvl != $past(acc_lvl));

    p_one_dir_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev));

    p_quiet_warm_r10: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !trig);
endmodule

bind icap_top icap_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tmr_val  (tmr_val),
    .flag_clr (flag_clr),
    .cap_val  (cap_val),
    .cap_flag (cap_flag),
    .trig     (trig),
    .armed    (armed),
    .acc_lvl  (acc_lvl),
    .ev       (ev)
);

// File: tb/icap_top_test.sv
`timescale 1ns/1ps
module icap_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_pin = 1'b0;
    logic [15:0] tmr_val = 16'hA5F0;
    logic        edge_rise = 1'b0;
    logic        filt_on = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_val;
    logic        cap_flag;

    int total = 0;
    int bad   = 0;

    icap_top uut (
        .clk       (clk),
        .rst       (rst),
        .cap_pin   (cap_pin),
        .tmr_val   (tmr_val),
        .edge_rise (edge_rise),
        .filt_on   (filt_on),
        .flag_clr  (flag_clr),
        .cap_val   (cap_val),
        .cap_flag  (cap_flag)
    );

    // 200 MHz; the model timer advances right after each falling edge
    initial begin
        forever begin
            #2.5 clk = 1'b1;
            #2.5 clk = 1'b0;
            tmr_val = tmr_val + 16'd1;
        end
    end

    typedef struct packed {
        logic       filt;
        logic       sel;
        logic       start;
        logic [3:0] glen;   // 0 = permanent change
        logic       exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 4'd0, 1'b1},  // R2 falling, unfiltered
        '{1'b0, 1'b0, 1'b0, 4'd0, 1'b0},  // R3 rising ignored
        '{1'b0, 1'b1, 1'b0, 4'd0, 1'b1},  // R3 rising selected
        '{1'b0, 1'b1, 1'b1, 4'd0, 1'b0},  // R3 falling ignored
        '{1'b1, 1'b0, 1'b1, 4'd0, 1'b1},  // R4 filtered falling
        '{1'b1, 1'b1, 1'b0, 4'd0, 1'b1},  // R4 filtered rising
        '{1'b1, 1'b1, 1'b0, 4'd3, 1'b0},  // R5 three-cycle glitch
        '{1'b1, 1'b0, 1'b1, 4'd2, 1'b0},  // R5 two-cycle glitch
        '{1'b1, 1'b1, 1'b0, 4'd4, 1'b1},  // R4 exactly four cycles
        '{1'b0, 1'b1, 1'b0, 4'd1, 1'b1}   // R2 single-cycle pulse
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_clr();
        cyc(1);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] c0;
        logic [15:0] keep;

        // R1 / R10: pin high through reset, rising edges selected
        cap_pin   = 1'b1;
        edge_rise = 1'b1;
        rst       = 1'b1;
        cyc(3);
        chk("R1 val in reset", 32'(cap_val), 32'h0);
        chk("R1 flag in reset", 32'(cap_flag), 32'h0);
        rst = 1'b0;
        cyc(1);
        chk("R1 val after reset", 32'(cap_val), 32'h0);
        chk("R1 flag after reset", 32'(cap_flag), 32'h0);
        cyc(20);
        chk("R10 no event at warm-up", 32'(cap_flag), 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            filt_on   = VEC[i].filt;
            edge_rise = VEC[i].sel;
            cap_pin   = VEC[i].start;
            cyc(12);
            pulse_clr();
            keep = cap_val;
            cyc(1);
            cap_pin = ~VEC[i].start;
            c0 = tmr_val;
            if (VEC[i].glen != 4'd0) begin
                cyc(int'(VEC[i].glen));
                cap_pin = VEC[i].start;
            end
            cyc(15);
            chk($sformatf("R2/R3/R4/R5 vec %0d flag", i), 32'(cap_flag), 32'(VEC[i].exp));
            if (VEC[i].exp)
                chk($sformatf("R7 vec %0d value", i), 32'(cap_val),
                    32'(c0 + (VEC[i].filt ? 16'd5 : 16'd2)));
            else
                chk($sformatf("R5 vec %0d value kept", i), 32'(cap_val), 32'(keep));
            if (VEC[i].glen == 4'd0 && VEC[i].exp) begin
                pulse_clr();
                chk("R7 flag cleared", 32'(cap_flag), 32'h0);
                cyc(20);
                chk("R6 no re-trigger", 32'(cap_flag), 32'h0);
            end
        end

        // R7: flag stays set across many cycles without a clear
        filt_on = 1'b0; edge_rise = 1'b0; cap_pin = 1'b1;
        cyc(10);
        pulse_clr();
        cap_pin = 1'b0;
        cyc(40);
        chk("R7 flag sticky", 32'(cap_flag), 32'h1);

        // R9: toggling polarity with a steady pin
        pulse_clr();
        keep = cap_val;
        for (int k = 0; k < 4; k++) begin
            edge_rise = ~edge_rise;
            cyc(3);
        end
        cap_pin = 1'b1;
        cyc(10);
        edge_rise = 1'b0;
        pulse_clr();
        for (int k = 0; k < 4; k++) begin
            edge_rise = ~edge_rise;
            cyc(3);
        end
        cyc(5);
        chk("R9 no event on polarity toggle", 32'(cap_flag), 32'h0);
        chk("R9 value unchanged", 32'(cap_val), 32'(keep));

        // R8: clear strobe on the very edge that captures
        edge_rise = 1'b0;
        cap_pin = 1'b1;
        cyc(10);
        pulse_clr();
        cyc(1);
        cap_pin = 1'b0;
        c0 = tmr_val;
        cyc(2);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        chk("R8 capture beats clear", 32'(cap_flag), 32'h1);
        chk("R8 value", 32'(cap_val), 32'(c0 + 16'd2));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule